// File: doc/BRIEF.md
# Interrupt Mask Controller

This block collects a set of level-type interrupt request lines and folds them into a single interrupt output for a processor. Every line has a pending bit and an enable bit. The output is raised whenever at least one line is both pending and enabled. Request lines arrive from other clock domains, so each one passes through a two-flop synchroniser. Pending bits then change on the detected transitions, not on the raw level.

Software reaches the block through a small 32-bit register window on a simple memory-mapped bus. Each access is a select, a write enable, an address and write data, and it completes with a one-cycle ready pulse. The window returns the number of active lines and the active mask. It also lets software set or clear individual enable bits, and a single command drops every enable and every pending bit at once. A separate read port, indexed by line number, returns a per-line count of how many rising transitions each request has produced.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset, pending, enable and every per-line counter are zero, `irq_o` is low and `bus_ready_o` is low.
- R2: An access starts when `bus_sel_i` is high and `bus_ready_o` is low at a clock edge. `bus_ready_o` is then high for exactly one cycle, and a write takes effect once, at the starting edge.
- R3: A read at offset 0x00 returns the number of bits set in (pending AND enable), a value from 0 to the line count.
- R4: A read at offset 0x04 returns (pending AND enable), with line n in bit n, never the raw pending bits.
- R5: A write at offset 0x10 sets each enable bit whose write-data bit is 1 and leaves the other enable bits unchanged.
- R6: A write at offset 0x0C clears each enable bit whose write-data bit is 1 and leaves the other enable bits unchanged.
- R7: Any write at offset 0x08 clears the whole enable mask and the whole pending register, whatever the data.
- R8: A rise on request line n sets pending bit n, and a fall clears it, at the third clock edge after the input changes (two synchroniser flops plus the edge detector).
- R9: `irq_o` is high exactly when (pending AND enable) is non-zero, and it updates at the same edge as the state it depends on.
- R10: Reads at any offset other than 0x00 and 0x04 return 0. Writes to 0x00, to 0x04 or to unmapped offsets change nothing.
- R11: The counter of line n increments on each rising transition of that line. It wraps on overflow, and `cnt_val_o` shows the count of the line selected by `cnt_sel_i`.
- R12: If a request transition is detected at the same edge as a write at 0x08, the write takes effect first and the transition is applied to pending one edge later.
- R13: A line that stays high through a write at 0x08 stays non-pending until it goes low and then high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req_i | input | NUM_LINES | Level interrupt requests, asynchronous |
| bus_sel_i | input | 1 | Access select, held until ready |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset into the register window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid while ready is high |
| bus_ready_o | output | 1 | One-cycle access completion |
| irq_o | output | 1 | Combined interrupt toward the processor |
| cnt_sel_i | input | IDX_W | Line index for the counter read port |
| cnt_val_o | output | CNT_W | Rising-transition count of the selected line |

## Verification
The masking path is tried with three mixes of request levels and enable bits: lines pending but not enabled, lines enabled but not pending, and lines with both bits set. Only the third kind may reach the mask, the count and the interrupt, so a design that reports raw pending bits fails at once. Request edges are placed against the disable-all command at three points: well before it, exactly on the same edge, and after it. These cases separate a correctly deferred event from one that is lost or cleared, and they confirm that a held level does not come back as pending on its own. Latency is probed one edge before and at the edge where a transition must appear, which catches a synchroniser stage too many or too few.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;

    // Byte offsets inside the register window
    localparam logic [7:0] OFS_COUNT   = 8'h00;
    localparam logic [7:0] OFS_ACTIVE  = 8'h04;
    localparam logic [7:0] OFS_WIPE    = 8'h08;
    localparam logic [7:0] OFS_MASKOFF = 8'h0C;
    localparam logic [7:0] OFS_MASKON  = 8'h10;

    localparam int unsigned BUS_DW = 32;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_RD_COUNT,
        OP_RD_ACTIVE,
        OP_WIPE,
        OP_MASK_OFF,
        OP_MASK_ON
    } reg_op_e;

endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned STAGES    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] req_i,
    output logic [NUM_LINES-1:0] rise_o,
    output logic [NUM_LINES-1:0] fall_o
);
    logic [STAGES-1:0][NUM_LINES-1:0] chain_q;
    logic [NUM_LINES-1:0]             prev_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= '0;
                else        chain_q[s] <= req_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= '0;
                else        chain_q[s] <= chain_q[s-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign rise_o = chain_q[STAGES-1] & ~prev_q;
    assign fall_o = ~chain_q[STAGES-1] & prev_q;

endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_mask_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              sel_i,
    input  logic              we_i,
    input  logic              busy_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              start_o,
    output reg_op_e           op_o
);
    always_comb begin
        start_o = sel_i & ~busy_i;
        op_o    = OP_NONE;
        if (start_o) begin
            if (!we_i) begin
                if (addr_i == ADDR_W'(OFS_COUNT))       op_o = OP_RD_COUNT;
                else if (addr_i == ADDR_W'(OFS_ACTIVE)) op_o = OP_RD_ACTIVE;
            end else begin
                if (addr_i == ADDR_W'(OFS_WIPE))         op_o = OP_WIPE;
                else if (addr_i == ADDR_W'(OFS_MASKOFF)) op_o = OP_MASK_OFF;
                else if (addr_i == ADDR_W'(OFS_MASKON))  op_o = OP_MASK_ON;
            end
        end
    end

endmodule

// File: rtl/irq_event_cnt.sv
module irq_event_cnt #(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned CNT_W     = 32,
    parameter int unsigned IDX_W     = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] rise_i,
    input  logic [IDX_W-1:0]     idx_i,
    output logic [CNT_W-1:0]     val_o
);
    logic [CNT_W-1:0] cnt_q [NUM_LINES];

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         cnt_q[n] <= '0;
            else if (rise_i[n]) cnt_q[n] <= cnt_q[n] + CNT_W'(1);
        end
    end

    always_comb begin
        val_o = '0;
        for (int n = 0; n < NUM_LINES; n++) begin
            if (int'(idx_i) == n) val_o = cnt_q[n];
        end
    end

endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
    import irq_mask_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned ADDR_W    = 6,
    parameter int unsigned CNT_W     = 32,
    parameter int unsigned SYNC_STG  = 2,
    parameter int unsigned IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_req_i,
    input  logic                 bus_sel_i,
    input  logic                 bus_we_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [31:0]          bus_wdata_i,
    output logic [31:0]          bus_rdata_o,
    output logic                 bus_ready_o,
    output logic                 irq_o,
    input  logic [IDX_W-1:0]     cnt_sel_i,
    output logic [CNT_W-1:0]     cnt_val_o
);
    localparam int unsigned POP_W = $clog2(NUM_LINES + 1);

    typedef struct packed {
        logic [NUM_LINES-1:0] pend;
        logic [NUM_LINES-1:0] en;
        logic [NUM_LINES-1:0] hold_rise;
        logic [NUM_LINES-1:0] hold_fall;
        logic                 ready;
        logic [BUS_DW-1:0]    rdata;
        logic                 irq;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_LINES-1:0] rise, fall;
    logic                 acc_start;
    reg_op_e              op;
    logic [NUM_LINES-1:0] pend_q, en_q;

    irq_line_sync #(
        .NUM_LINES (NUM_LINES),
        .STAGES    (SYNC_STG)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (irq_req_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    irq_reg_decode #(
        .ADDR_W (ADDR_W)
    ) u_dec (
        .sel_i   (bus_sel_i),
        .we_i    (bus_we_i),
        .busy_i  (st_q.ready),
        .addr_i  (bus_addr_i),
        .start_o (acc_start),
        .op_o    (op)
    );

    irq_event_cnt #(
        .NUM_LINES (NUM_LINES),
        .CNT_W     (CNT_W),
        .IDX_W     (IDX_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .rise_i(rise),
        .idx_i (cnt_sel_i),
        .val_o (cnt_val_o)
    );

    function automatic logic [POP_W-1:0] pop_cnt(input logic [NUM_LINES-1:0] v);
        logic [POP_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < NUM_LINES; i++) acc = acc + POP_W'(v[i]);
        return acc;
    endfunction

    always_comb begin
        logic [NUM_LINES-1:0] active;
        logic [NUM_LINES-1:0] settled;
        logic [NUM_LINES-1:0] wmask;

        st_d    = st_q;
        active  = st_q.pend & st_q.en;
        wmask   = bus_wdata_i[NUM_LINES-1:0];
        // Events deferred from the previous edge go first
        settled = (st_q.pend | st_q.hold_rise) & ~st_q.hold_fall;

        st_d.ready = acc_start;
        if (acc_start) begin
            case (op)
                OP_RD_COUNT:  st_d.rdata = BUS_DW'(pop_cnt(active));
                OP_RD_ACTIVE: st_d.rdata = BUS_DW'(active);
                default:      st_d.rdata = '0;
            endcase
        end

        if (op == OP_WIPE) begin
            st_d.pend      = '0;
            st_d.en        = '0;
            st_d.hold_rise = rise;
            st_d.hold_fall = fall;
        end else begin
            st_d.pend      = (settled | rise) & ~fall;
            st_d.hold_rise = '0;
            st_d.hold_fall = '0;
            if (op == OP_MASK_OFF)     st_d.en = st_q.en & ~wmask;
            else if (op == OP_MASK_ON) st_d.en = st_q.en | wmask;
        end

        st_d.irq = |(st_d.pend & st_d.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_ready_o = st_q.ready;
    assign bus_rdata_o = st_q.rdata;
    assign irq_o       = st_q.irq;
    assign pend_q      = st_q.pend;
    assign en_q        = st_q.en;

endmodule

// File: rtl/irq_mask_ctrl_chk.sv
module irq_mask_ctrl_chk
    import irq_mask_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned ADDR_W    = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_sel_i,
    input logic                 bus_we_i,
    input logic [ADDR_W-1:0]    bus_addr_i,
    input logic [31:0]          bus_wdata_i,
    input logic [31:0]          bus_rdata_o,
    input logic                 bus_ready_o,
    input logic                 irq_o,
    input logic [NUM_LINES-1:0] pend_q,
    input logic [NUM_LINES-1:0] en_q
);
    logic go_rd, go_wr, at_count, at_active;
    assign go_rd     = bus_sel_i & ~bus_we_i & ~bus_ready_o;
    assign go_wr     = bus_sel_i &  bus_we_i & ~bus_ready_o;
    assign at_count  = (bus_addr_i == ADDR_W'(OFS_COUNT));
    assign at_active = (bus_addr_i == ADDR_W'(OFS_ACTIVE));

    p_ready_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready_o |=> !bus_ready_o);

    p_ready_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_i && !bus_ready_o) |=> bus_ready_o);

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (go_rd && at_count) |=> (bus_rdata_o <= 32'(NUM_LINES)));

    p_mask_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (go_wr && bus_addr_i == ADDR_W'(OFS_MASKON))
        |=> ((en_q & $past(bus_wdata_i[NUM_LINES-1:0])) == $past(bus_wdata_i[NUM_LINES-1:0])));

    p_mask_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (go_wr && bus_addr_i == ADDR_W'(OFS_MASKOFF))
        |=> ((en_q & $past(bus_wdata_i[NUM_LINES-1:0])) == '0));

    p_wipe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (go_wr && bus_addr_i == ADDR_W'(OFS_WIPE)) |=> (en_q == '0 && pend_q == '0));

    p_irq_tracks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == |(pend_q & en_q));

    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (go_rd && !at_count && !at_active) |=> (bus_rdata_o == '0));

    p_rdonly_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (go_wr && (at_count || at_active)) |=> (en_q == $past(en_q)));

endmodule

bind irq_mask_ctrl irq_mask_ctrl_chk #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel_i   (bus_sel_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .bus_ready_o (bus_ready_o),
    .irq_o       (irq_o),
    .pend_q      (pend_q),
    .en_q        (en_q)
);

// File: tb/irq_mask_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_mask_ctrl_tb_top;
    localparam int unsigned NL = 32;
    localparam int unsigned AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] req = '0;
    logic          sel = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          ready;
    logic          irq;
    logic [4:0]    cnt_sel = '0;
    logic [31:0]   cnt_val;

    int unsigned n_chk = 0;
    int unsigned n_fail = 0;
    int unsigned exp_cnt [NL];
    bit          done = 1'b0;

    always #2 clk = ~clk;

    irq_mask_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_req_i   (req),
        .bus_sel_i   (sel),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .bus_ready_o (ready),
        .irq_o       (irq),
        .cnt_sel_i   (cnt_sel),
        .cnt_val_o   (cnt_val)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; addr = AW'(a); wdata = d;
        @(posedge clk); #1;
        chk("R2 ready after write", 32'(ready), 32'd1);
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
        @(posedge clk); #1;
        chk("R2 ready one cycle", 32'(ready), 32'd0);
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b0; addr = AW'(a);
        @(posedge clk); #1;
        chk("R2 ready after read", 32'(ready), 32'd1);
        d = rdata;
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic line_set(input int n, input logic v);
        @(negedge clk);
        if (v && !req[n]) exp_cnt[n]++;
        req[n] = v;
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        #1;
        chk("R1 irq in reset", 32'(irq), 32'd0);
        chk("R1 ready in reset", 32'(ready), 32'd0);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        bus_rd(8'h00, d); chk("R1 count after reset", d, 32'd0);
        bus_rd(8'h04, d); chk("R1 mask after reset", d, 32'd0);
        cnt_sel = 5'd3; #1;
        chk("R1 counter after reset", cnt_val, 32'd0);
    endtask

    task automatic t_latency();
        bus_wr(8'h10, 32'h0000_1000);
        @(negedge clk);
        req[12] = 1'b1; exp_cnt[12]++;
        repeat (2) @(posedge clk); #1;
        chk("R8 rise not before third edge", 32'(irq), 32'd0);
        @(posedge clk); #1;
        chk("R8 rise at third edge", 32'(irq), 32'd1);
        @(negedge clk);
        req[12] = 1'b0;
        repeat (2) @(posedge clk); #1;
        chk("R8 fall not before third edge", 32'(irq), 32'd1);
        @(posedge clk); #1;
        chk("R9 irq drops with fall", 32'(irq), 32'd0);
        bus_wr(8'h0C, 32'h0000_1000);
    endtask

    task automatic t_masking();
        logic [31:0] d;
        bus_wr(8'h10, 32'h0000_00F0);
        chk("R9 enabled but idle", 32'(irq), 32'd0);
        line_set(4, 1'b1);
        line_set(5, 1'b1);
        line_set(9, 1'b1);
        bus_rd(8'h04, d); chk("R4 mask hides disabled pending", d, 32'h0000_0030);
        bus_rd(8'h00, d); chk("R3 count two", d, 32'd2);
        chk("R9 irq with active lines", 32'(irq), 32'd1);
        bus_wr(8'h10, 32'h0000_0200);
        bus_rd(8'h04, d); chk("R5 enable adds line 9", d, 32'h0000_0230);
        bus_rd(8'h00, d); chk("R3 count three", d, 32'd3);
        bus_wr(8'h0C, 32'h0000_0010);
        bus_rd(8'h04, d); chk("R6 disable removes line 4 only", d, 32'h0000_0220);
        bus_wr(8'h0C, 32'h0000_0220);
        bus_rd(8'h00, d); chk("R6 all disabled count", d, 32'd0);
        chk("R9 irq low when nothing enabled", 32'(irq), 32'd0);
        bus_wr(8'h10, 32'h0000_0230);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        bus_rd(8'h14, d); chk("R10 read 0x14", d, 32'd0);
        bus_rd(8'h20, d); chk("R10 read 0x20", d, 32'd0);
        bus_rd(8'h10, d); chk("R10 read write-only", d, 32'd0);
        bus_wr(8'h00, 32'hFFFF_FFFF);
        bus_wr(8'h04, 32'hFFFF_FFFF);
        bus_wr(8'h18, 32'hFFFF_FFFF);
        bus_rd(8'h04, d); chk("R10 writes to ro/unmapped ignored", d, 32'h0000_0230);
    endtask

    task automatic t_wipe();
        logic [31:0] d;
        bus_wr(8'h08, 32'h1234_5678);
        bus_rd(8'h04, d); chk("R7 mask cleared", d, 32'd0);
        chk("R7 irq low after wipe", 32'(irq), 32'd0);
        bus_wr(8'h10, 32'hFFFF_FFFF);
        bus_rd(8'h04, d); chk("R7 R13 pending stays clear with held lines", d, 32'd0);
        line_set(5, 1'b0);
        line_set(5, 1'b1);
        bus_rd(8'h04, d); chk("R13 new edge re-pends line 5", d, 32'h0000_0020);
        bus_wr(8'h0C, 32'hFFFF_FFFF);
    endtask

    task automatic t_defer();
        logic [31:0] d;
        @(negedge clk);
        req[20] = 1'b1; exp_cnt[20]++;
        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; addr = AW'(8'h08); wdata = '0;
        @(posedge clk); #1;
        chk("R2 ready on wipe", 32'(ready), 32'd1);
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
        bus_wr(8'h10, 32'h0010_0020);
        bus_rd(8'h04, d); chk("R12 coincident rise kept after wipe", d, 32'h0010_0000);
        chk("R9 irq from deferred line", 32'(irq), 32'd1);
    endtask

    task automatic t_counters();
        for (int k = 0; k < 3; k++) begin
            line_set(7, 1'b1);
            line_set(7, 1'b0);
        end
        cnt_sel = 5'd7;  #1; chk("R11 line 7 count", cnt_val, 32'(exp_cnt[7]));
        cnt_sel = 5'd5;  #1; chk("R11 line 5 count", cnt_val, 32'(exp_cnt[5]));
        cnt_sel = 5'd12; #1; chk("R11 line 12 count", cnt_val, 32'(exp_cnt[12]));
        cnt_sel = 5'd20; #1; chk("R11 R12 line 20 count", cnt_val, 32'(exp_cnt[20]));
        cnt_sel = 5'd0;  #1; chk("R11 idle line count", cnt_val, 32'(exp_cnt[0]));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired, actual=hung expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NL; i++) exp_cnt[i] = 0;
        t_reset();
        t_latency();
        t_masking();
        t_unmapped();
        t_wipe();
        t_defer();
        t_counters();
        finish_run();
    end

endmodule